// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the master side of a PHY management port. Software writes one 32-bit command word. The word packs the start pattern, the operation, the PHY address, the register address and sixteen bits of data. The block then drives a full clause-22 management frame on MDC and MDIO. A frame is a run of one bits followed by the command word, sent most significant bit first.

On a read, the block stops driving MDIO at the turnaround field. It samples the sixteen data bits that the PHY returns and shifts them into the low half of the same command word, where software reads them back. An idle flag tells software when the port is free to accept a new command.

The MDC period is a divide of the block clock. One of two divisors is picked by a select input, and the choice is latched when a command starts. The port operates only while its enable input is high.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: An accepted command produces a frame of PRE_LEN (32) one bits followed by the 32 command bits, most significant first, with one frame bit per MDC period. MDIO is driven (mdio_oe high) for every bit that belongs to the master.
- R2: Frame bits 31:30 are always sent as 01 (start) and bits 17:16 as 10 (turnaround), whatever was written to those positions.
- R3: The MDC period is DIV_LO clocks when div_sel is 0 and DIV_HI clocks when div_sel is 1. MDC is low for the first half of each period and high for the second half, and it stays low whenever the port is idle.
- R4: When command bit 29 (read) is set, mdio_oe goes low from frame bit PRE_LEN+14 (the first turnaround bit) until the frame ends. Otherwise mdio_oe stays high for the whole frame.
- R5: On a read, mdio_i is sampled in the clock before each MDC rising edge of frame bits PRE_LEN+16 to PRE_LEN+31 and shifted into cmd_word[15:0], first bit ending at bit 15. Bits 31:16 are kept. A write leaves the whole word unchanged.
- R6: A cmd_wr pulse while idle and enabled is accepted. In the next cycle idle is low and cmd_word equals the written value.
- R7: A cmd_wr while a frame is running is ignored. The word and the running frame are unaffected.
- R8: idle returns high exactly (PRE_LEN+32)×divisor clocks after acceptance, which is the end of the last MDC period. MDC and mdio_oe are low whenever idle is high.
- R9: While mgmt_en is low, writes are ignored. Dropping mgmt_en during a frame abandons it: in the next cycle idle is high and MDC and mdio_oe are low.
- R10: After reset, idle is 1, mdc is 0, mdio_oe is 0, mdio_o is 1 and cmd_word is 0.
- R11: Changing div_sel during a frame does not affect that frame's MDC period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 1 | MDC divisor select (0: DIV_LO, 1: DIV_HI) |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word to write |
| cmd_word | output | 32 | Stored command word, with read data in the low half |
| idle | output | 1 | Port idle, a new command may be written |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with divisors of 4 and 6 and the full 32-bit preamble. With these short bit periods, several complete read and write frames on both divide paths fit in a few thousand clocks, and a mid-frame change of the select is observable. Because both divisors are even but unequal, a wrong half-period point or a divisor that is not latched shows up as an MDC mismatch within one bit. The 32 and 48 defaults differ only in the counter limit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int CMD_W  = 32;
   localparam int DATA_W = 16;
   localparam int RD_POS = 29;

   // Force the start pattern (01) and the turnaround pattern (10) into the frame image.
   function automatic logic [CMD_W-1:0] frame_image(input logic [CMD_W-1:0] w);
      logic [CMD_W-1:0] f;
      f        = w;
      f[31:30] = 2'b01;
      f[17:16] = 2'b10;
      return f;
   endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_LO = 32,
   parameter int DIV_HI = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic sel,
   output logic mdc,
   output logic rise_tick,
   output logic bit_end
);
   localparam int MAXD = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
   localparam int CW   = $clog2(MAXD + 1);
   localparam logic [CW-1:0] N_LO = CW'(DIV_LO);
   localparam logic [CW-1:0] N_HI = CW'(DIV_HI);

   if (DIV_LO < 2 || (DIV_LO % 2) != 0) begin : g_bad_lo
      $error("DIV_LO must be even and at least 2");
   end
   if (DIV_HI < 2 || (DIV_HI % 2) != 0) begin : g_bad_hi
      $error("DIV_HI must be even and at least 2");
   end

   logic [CW-1:0] n_pick, n_q, cnt, half_m1, last;

   if (DIV_LO == DIV_HI) begin : g_single
      assign n_pick = N_LO;
   end else begin : g_dual
      assign n_pick = sel ? N_HI : N_LO;
   end

   assign half_m1   = (n_q >> 1) - 1'b1;
   assign last      = n_q - 1'b1;
   assign rise_tick = run && (cnt == half_m1);
   assign bit_end   = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q <= N_LO;
         cnt <= '0;
         mdc <= 1'b0;
      end else if (start) begin
         n_q <= n_pick;
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run || bit_end) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
         if (rise_tick) mdc <= 1'b1;
      end
   end

   // R3: MDC rises only at the half-period point of a bit
   p_mdc_mid_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> (cnt == (n_q >> 1)));
   // R3: MDC falls back low when the divider is not running
   p_mdc_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        abort,
   input  logic        rd,
   input  logic [31:0] frame,
   input  logic        bit_end,
   input  logic        rise_tick,
   output logic        busy,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        cap
);
   localparam int FRAME_LEN = PRE_LEN + 32;
   localparam int IW        = $clog2(FRAME_LEN);
   localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);
   localparam logic [IW-1:0] TA_IDX   = IW'(PRE_LEN + 14);
   localparam logic [IW-1:0] DAT_IDX  = IW'(PRE_LEN + 16);

   if (PRE_LEN < 0 || PRE_LEN > 64) begin : g_bad_pre
      $error("PRE_LEN must lie in 0..64");
   end

   logic [IW-1:0] idx;
   logic [4:0]    pos;
   logic          in_pre;

   assign pos = 5'(LAST_IDX - idx);

   if (PRE_LEN > 0) begin : g_pre
      localparam logic [IW-1:0] CMD_IDX = IW'(PRE_LEN);
      assign in_pre = (idx < CMD_IDX);
   end else begin : g_nopre
      assign in_pre = 1'b0;
   end

   assign mdio_o  = !busy || in_pre || frame[pos];
   assign mdio_oe = busy && !(rd && (idx >= TA_IDX));
   assign cap     = busy && rd && rise_tick && (idx >= DAT_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy && bit_end) begin
         if (idx == LAST_IDX) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R4: the master lets go of MDIO only at the turnaround of a read
   p_release_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $fell(mdio_oe)) |-> (rd && idx == TA_IDX));
   // R5: capture strobes never occur outside a read data phase
   p_capture_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> (rd && !mdio_oe));
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
   parameter int DIV_LO  = 32,
   parameter int DIV_HI  = 48,
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mgmt_en,
   input  logic        div_sel,
   input  logic        cmd_wr,
   input  logic [31:0] cmd_data,
   output logic [31:0] cmd_word,
   output logic        idle,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   import mdio_pkg::*;

   logic [CMD_W-1:0] cmd_q;
   logic busy, accept, cap, rise_tick, bit_end;

   assign accept   = cmd_wr && mgmt_en && !busy;
   assign idle     = !busy;
   assign cmd_word = cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (accept) begin
         cmd_q <= cmd_data;
      end else if (cap) begin
         cmd_q[DATA_W-1:0] <= {cmd_q[DATA_W-2:0], mdio_i};
      end
   end

   mdio_clk_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .run       (busy && mgmt_en),
      .sel       (div_sel),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .bit_end   (bit_end)
   );

   mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .abort     (!mgmt_en),
      .rd        (cmd_q[RD_POS]),
      .frame     (frame_image(cmd_q)),
      .bit_end   (bit_end),
      .rise_tick (rise_tick),
      .busy      (busy),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .cap       (cap)
   );

   // R6: an accepted write is stored and the port turns busy
   p_accept_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && cmd_wr && mgmt_en) |=> (!idle && cmd_word == $past(cmd_data)));
   // R7: a write during a frame leaves the word alone
   p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && cmd_wr && !cap) |=> (cmd_word == $past(cmd_word)));
   // R8: an idle port drives no clock and no data
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!mdc && !mdio_oe));
   // R9: a disabled port is idle one cycle later
   p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mgmt_en |=> idle);
endmodule

// File: tb/mdio_frame_ctrl_test.sv
module mdio_frame_ctrl_test;
   localparam int TB_LO = 4;
   localparam int TB_HI = 6;
   localparam int PRE   = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mgmt_en = 1'b0;
   logic div_sel = 1'b0;
   logic cmd_wr = 1'b0;
   logic [31:0] cmd_data = '0;
   logic mdio_i = 1'b1;
   logic [31:0] cmd_word;
   logic idle, mdc, mdio_o, mdio_oe;

   int checks = 0;
   int fails  = 0;
   int wd     = 0;

   // reference model state
   bit          m_busy = 1'b0;
   bit          m_read = 1'b0;
   int          m_cyc  = 0;
   int          m_n    = TB_LO;
   logic [31:0] m_word = '0;
   logic [15:0] resp   = '0;
   int          m_idx, m_cnt;
   logic [31:0] m_fw;
   logic        e_mdc, e_oe, e_o;

   always #4 clk = ~clk;

   mdio_frame_ctrl #(.DIV_LO(TB_LO), .DIV_HI(TB_HI), .PRE_LEN(PRE)) uut (
      .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .div_sel(div_sel),
      .cmd_wr(cmd_wr), .cmd_data(cmd_data), .cmd_word(cmd_word), .idle(idle),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // model update at the active edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 1'b0;
         m_word = '0;
         m_cyc  = 0;
      end else if (!mgmt_en) begin
         m_busy = 1'b0;
      end else if (!m_busy) begin
         if (cmd_wr) begin
            m_busy = 1'b1;
            m_cyc  = 0;
            m_word = cmd_data;
            m_n    = div_sel ? TB_HI : TB_LO;
            m_read = cmd_data[29];
         end
      end else begin
         if (m_read && (m_cyc / m_n) >= PRE + 16 && (m_cyc % m_n) == m_n / 2 - 1)
            m_word[15:0] = {m_word[14:0], mdio_i};
         if (m_cyc == (PRE + 32) * m_n - 1) m_busy = 1'b0;
         else m_cyc++;
      end
   end

   // per-cycle comparison away from the edge, then the PHY responder
   always @(negedge clk) begin
      if (rst_n) begin
         m_idx = m_cyc / m_n;
         m_cnt = m_cyc % m_n;
         m_fw  = m_word;
         m_fw[31:30] = 2'b01;
         m_fw[17:16] = 2'b10;
         e_mdc = m_busy && (m_cnt >= m_n / 2);
         e_oe  = m_busy && !(m_read && m_idx >= PRE + 14);
         e_o   = !m_busy || (m_idx < PRE) || m_fw[PRE + 31 - m_idx];
         check("R8 idle", {31'd0, idle}, {31'd0, !m_busy});
         check("R3 R11 mdc", {31'd0, mdc}, {31'd0, e_mdc});
         check("R4 mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
         if (e_oe || !m_busy) check("R1 R2 mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
         check("R5 cmd_word", cmd_word, m_word);
      end
      if (m_busy && m_read && (m_cyc / m_n) >= PRE + 16)
         mdio_i = resp[PRE + 31 - (m_cyc / m_n)];
      else
         mdio_i = 1'b1;
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic logic [31:0] mk(input bit rd, input logic [4:0] phy,
                                      input logic [4:0] rg, input logic [15:0] d);
      return {2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, d};
   endfunction

   task automatic issue(input logic [31:0] d);
      @(negedge clk);
      cmd_data = d;
      cmd_wr   = 1'b1;
      @(negedge clk);
      cmd_wr   = 1'b0;
   endtask

   task automatic wait_idle();
      while (!idle) @(negedge clk);
      @(negedge clk);
   endtask

   logic [31:0] w1, w2, rdc, bad;

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 idle", {31'd0, idle}, 32'd1);
      check("R10 mdc", {31'd0, mdc}, 32'd0);
      check("R10 mdio_oe", {31'd0, mdio_oe}, 32'd0);
      check("R10 mdio_o", {31'd0, mdio_o}, 32'd1);
      check("R10 cmd_word", cmd_word, 32'd0);
      rst_n   = 1'b1;
      mgmt_en = 1'b1;

      // R6: write frame, short divisor
      w1 = mk(1'b0, 5'd5, 5'd3, 16'hA5C3);
      issue(w1);
      check("R6 idle after accept", {31'd0, idle}, 32'd0);
      check("R6 stored word", cmd_word, w1);
      repeat (20) @(negedge clk);
      // R7: write while busy is ignored
      w2 = mk(1'b1, 5'd9, 5'd9, 16'h1111);
      issue(w2);
      check("R7 word kept", cmd_word, w1);
      wait_idle();
      check("R5 write word unchanged", cmd_word, w1);

      // R5 read with long divisor; R11 select flips mid-frame
      div_sel = 1'b1;
      resp    = 16'h3C96;
      rdc     = mk(1'b1, 5'd17, 5'd2, 16'h0000);
      issue(rdc);
      repeat (30) @(negedge clk);
      div_sel = 1'b0;
      wait_idle();
      check("R5 read data", cmd_word, {rdc[31:16], 16'h3C96});

      // R2: wrong start and turnaround bits are corrected on the wire
      bad = {2'b10, 2'b01, 5'h1F, 5'h00, 2'b01, 16'h0F0F};
      issue(bad);
      check("R2 stored as written", cmd_word, bad);
      wait_idle();

      // R9: write while disabled is ignored
      mgmt_en = 1'b0;
      issue(w2);
      check("R9 idle while disabled", {31'd0, idle}, 32'd1);
      check("R9 word unchanged", cmd_word, bad);
      mgmt_en = 1'b1;

      // R9: disable in mid-frame abandons it
      resp = 16'h5A5A;
      issue(rdc);
      repeat (100) @(negedge clk);
      mgmt_en = 1'b0;
      @(negedge clk);
      check("R9 abort idle", {31'd0, idle}, 32'd1);
      check("R9 abort mdc", {31'd0, mdc}, 32'd0);
      check("R9 abort oe", {31'd0, mdio_oe}, 32'd0);
      mgmt_en = 1'b1;

      // R5 R8: read returning all ones at the short divisor
      resp = 16'hFFFF;
      rdc  = mk(1'b1, 5'd0, 5'd31, 16'h0000);
      issue(rdc);
      wait_idle();
      check("R5 read ones", cmd_word, {rdc[31:16], 16'hFFFF});

      repeat (5) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule